// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block behaves like a small word-organized serial EEPROM that sits on a three-wire command bus. A bus master raises chip select, clocks in a start bit, a two-bit opcode and a word address, then clocks in sixteen data bits or clocks out sixteen data bits. The array holds `2**ADDR_W` words of `DATA_W` bits. `ADDR_W` is 6 for the small configuration and 8 for the large one. The model stands in for a real part in a system, so that controller logic that boots from a serial configuration store can run against it.

All inputs are sampled in the `clk` domain. A rising serial clock edge is found by comparing `sck` with its value on the previous `clk` cycle. A write-enable latch guards the array: every command that changes stored data is dropped while the latch is clear. Programming finishes in the same `clk` cycle as the last bit of the command, and the block has no busy period.

Top module: `mw_eeprom_model`

## Requirements
- R1: A command starts only when `din` is 1 on a rising `sck` edge while `cs` is high and the block is idle. Zeros clocked in before that start bit are ignored.
- R2: Opcode bits 10 after the start bit select a read. On the rising edge that takes the last address bit, `dout` goes to 0. Each of the next 16 rising edges then drives one stored bit, most significant first.
- R3: Opcode 01 takes an address and then 16 data bits, most significant first. If the write-enable latch is set, the word at that address is replaced on the last data bit.
- R4: Opcode 11 sets the addressed word to 16'hFFFF if the write-enable latch is set.
- R5: For opcode 00, the two most significant address bits pick the command, and the lower address bits have no effect. 11 sets the write-enable latch and 00 clears it.
- R6: Opcode 00 with top address bits 10 sets every word to 16'hFFFF if the write-enable latch is set.
- R7: Opcode 00 with top address bits 01, followed by 16 data bits, writes that value to every word if the write-enable latch is set.
- R8: Reset clears the write-enable latch and fills the array with 16'hFFFF. While the latch is clear, write, erase, erase-all and write-all leave the array unchanged.
- R9: `dout_en` is 0 whenever `cs` is low. It is 1 from the read's leading 0 until `cs` falls, and 0 at all other times.
- R10: If `cs` goes low before a command is complete, the command is discarded and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all inputs and state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; rising edges shift bits |
| din | input | 1 | Serial data from the bus master |
| dout | output | 1 | Serial read data |
| dout_en | output | 1 | High when `dout` is driven; low means high impedance |

## Verification
The hardest state to reach is a locked array that receives a full, well-formed programming command. The checks must show that the array is still intact afterwards, and this can only be seen by reading the words back later. The stimulus stores a known word, clears the latch, and then sends both a write and an erase to that address. A read then checks that the old value is still there. Aborted commands work the same way: the bench drops `cs` partway through the data bits of a write, and a later read proves that the array kept its old value.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DAT,
    ST_RD,
    ST_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  typedef enum logic [1:0] {
    EX_LOCK   = 2'b00,
    EX_FILL   = 2'b01,
    EX_WIPE   = 2'b10,
    EX_UNLOCK = 2'b11
  } mw_ext_e;

  // Serial shift helper: append the new bit at the LSB end.
  function automatic logic [1:0] push2(input logic [1:0] v, input logic b);
    return {v[0], b};
  endfunction

endpackage

// File: rtl/mw_sck_edge.sv
module mw_sck_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic sck_rise
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise = sck & ~sck_q;

  // R1: a detected edge cannot repeat on back-to-back cycles
  a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_one,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_all || (wr_one && wr_addr == ADDR_W'(i))) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // R3: a single-word store is visible on the following cycle
  a_r3_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_one |=> mem[$past(wr_addr)] == $past(wr_data));

  // R7: whole-array store reaches both ends of the array
  a_r7_all_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_all |=> (mem[0] == $past(wr_data)) && (mem[DEPTH-1] == $past(wr_data)));

  // R6: single and whole-array strobes never coincide
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_one, wr_all}));
endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              din,
  input  logic              sck_rise,
  output logic              wr_one,
  output logic              wr_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dout,
  output logic              rd_active
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  mw_state_e         state;
  mw_op_e            op_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W-1:0] rd_sh;
  logic              wen_q;

  // Named internal events
  logic              step, last_adr, last_dat;
  logic [ADDR_W-1:0] adr_next;
  logic [DATA_W-1:0] dat_next;
  mw_ext_e           ext;
  logic              ev_erase, ev_wipe, ev_write, ev_fill, ev_unlock, ev_lock;

  assign step     = cs & sck_rise;
  assign last_adr = step && state == ST_ADR && cnt == ADR_LAST;
  assign last_dat = step && state == ST_DAT && cnt == DAT_LAST;
  assign adr_next = {adr_q[ADDR_W-2:0], din};
  assign dat_next = {dat_q[DATA_W-2:0], din};
  assign ext      = mw_ext_e'(adr_next[ADDR_W-1 -: 2]);

  assign ev_erase  = last_adr && op_q == OP_ERASE;
  assign ev_wipe   = last_adr && op_q == OP_EXT && ext == EX_WIPE;
  assign ev_unlock = last_adr && op_q == OP_EXT && ext == EX_UNLOCK;
  assign ev_lock   = last_adr && op_q == OP_EXT && ext == EX_LOCK;
  assign ev_write  = last_dat && op_q == OP_WRITE;
  assign ev_fill   = last_dat && op_q == OP_EXT;

  assign wr_one  = wen_q & (ev_erase | ev_write);
  assign wr_all  = wen_q & (ev_wipe | ev_fill);
  assign wr_addr = (state == ST_ADR) ? adr_next : adr_q;
  assign wr_data = (ev_erase | ev_wipe) ? '1 : dat_next;
  assign rd_addr = adr_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wen_q <= 1'b0;
    else if (ev_unlock) wen_q <= 1'b1;
    else if (ev_lock)   wen_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= OP_EXT;
      cnt       <= '0;
      adr_q     <= '0;
      dat_q     <= '0;
      rd_sh     <= '0;
      dout      <= 1'b0;
      rd_active <= 1'b0;
    end else if (!cs) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rd_active <= 1'b0;
    end else if (sck_rise) begin
      unique case (state)
        ST_IDLE: if (din) begin
          state <= ST_OPC;
          cnt   <= '0;
        end
        ST_OPC: begin
          op_q <= mw_op_e'(push2(op_q, din));
          if (cnt == CNT_W'(1)) begin
            state <= ST_ADR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_ADR: begin
          adr_q <= adr_next;
          if (cnt == ADR_LAST) begin
            cnt <= '0;
            if (op_q == OP_READ) begin
              state     <= ST_RD;
              dout      <= 1'b0;
              rd_active <= 1'b1;
              rd_sh     <= rd_data;
            end else if (op_q == OP_WRITE || (op_q == OP_EXT && ext == EX_FILL)) begin
              state <= ST_DAT;
            end else begin
              state <= ST_HOLD;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_DAT: begin
          dat_q <= dat_next;
          if (cnt == DAT_LAST) state <= ST_HOLD;
          else cnt <= cnt + 1'b1;
        end
        ST_RD: begin
          dout  <= rd_sh[DATA_W-1];
          rd_sh <= {rd_sh[DATA_W-2:0], 1'b1};
          if (cnt == DAT_LAST) state <= ST_HOLD;
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8: the array is only strobed while the latch is set
  a_r8_prog_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one | wr_all) |-> wen_q);

  // R9: dropping select ends the output phase
  a_r9_drop_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !rd_active);

  // R2: serial output moves only on a clock edge
  a_r2_dout_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(dout));

  // R5: latch changes only on a serial edge
  a_r5_wen_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(wen_q));

  // R1: idle is left only through a start bit
  a_r1_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(step && din)) |=> state == ST_IDLE);

  // R10: deselect returns to idle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> state == ST_IDLE);
endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic din,
  output logic dout,
  output logic dout_en
);
  logic              sck_rise;
  logic              wr_one, wr_all, rd_active;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  mw_sck_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .sck_rise (sck_rise)
  );

  mw_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .din       (din),
    .sck_rise  (sck_rise),
    .wr_one    (wr_one),
    .wr_all    (wr_all),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .dout      (dout),
    .rd_active (rd_active)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_one  (wr_one),
    .wr_all  (wr_all),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign dout_en = cs & rd_active;

  // R9: never driven while deselected
  a_r9_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout_en);
endmodule

// File: tb/mw_eeprom_model_bench.sv
module mw_eeprom_model_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, din = 1'b0;
  logic dout, dout_en;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [15:0] mdl [DEPTH];
  bit  mdl_wen = 1'b0;
  logic exp_en = 1'b0;
  logic exp_dout = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom_model #(.ADDR_W(AW), .DATA_W(16)) u_mw_eeprom_model (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(posedge clk) begin
    #5;
    if (mon_on && !done) begin
      check(dout_en === exp_en, "R9 dout_en", {15'd0, dout_en}, {15'd0, exp_en});
      if (exp_en) check(dout === exp_dout, "R2 dout", {15'd0, dout}, {15'd0, exp_dout});
    end
  end

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; sck = 1'b0;
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; sck = 1'b0; din = 1'b0; exp_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // One serial bit; returns just after the clk edge that consumes it
  task automatic clk_bit(input logic b);
    @(negedge clk); din = b; sck = 1'b0;
    @(negedge clk); sck = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic send_head(input logic [1:0] op, input int addr, input int lead);
    cs_up();
    for (int i = 0; i < lead; i++) clk_bit(1'b0);
    clk_bit(1'b1); clk_bit(op[1]); clk_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) clk_bit(addr[i]);
  endtask

  task automatic do_read(input int addr, input int lead, input string tag);
    logic [15:0] got;
    send_head(2'b10, addr, lead);
    exp_en = 1'b1; exp_dout = 1'b0;
    check(dout === 1'b0 && dout_en === 1'b1, "R2 leading zero", {15'd0, dout}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0);
      exp_dout = mdl[addr][i];
      got[i] = dout;
    end
    cs_down();
    check(got === mdl[addr], tag, got, mdl[addr]);
  endtask

  task automatic do_prog(input logic [1:0] op, input int addr, input bit has_data,
                         input logic [15:0] data);
    send_head(op, addr, 0);
    if (has_data) for (int i = 15; i >= 0; i--) clk_bit(data[i]);
    cs_down();
  endtask

  task automatic m_write(input int a, input logic [15:0] d);
    do_prog(2'b01, a, 1'b1, d);
    if (mdl_wen) mdl[a] = d;
  endtask

  task automatic m_erase(input int a);
    do_prog(2'b11, a, 1'b0, 16'h0);
    if (mdl_wen) mdl[a] = 16'hFFFF;
  endtask

  task automatic m_ext(input int top2, input int low, input logic [15:0] d);
    int a;
    a = (top2 << (AW - 2)) | (low & ((1 << (AW - 2)) - 1));
    do_prog(2'b00, a, top2 == 1, d);
    case (top2)
      3: mdl_wen = 1'b1;
      0: mdl_wen = 1'b0;
      2: if (mdl_wen) for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
      1: if (mdl_wen) for (int i = 0; i < DEPTH; i++) mdl[i] = d;
      default: ;
    endcase
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(dout_en === 1'b0, "R8 reset dout_en", {15'd0, dout_en}, 16'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    // R8: locked after reset, array all ones
    m_write(5, 16'hDEAD);
    do_read(5, 0, "R8 write refused after reset");
    do_read(0, 0, "R8 reset contents");

    // R5: unlock with arbitrary low bits
    m_ext(3, 5, 16'h0);
    m_write(5, 16'hDEAD);
    m_write(DEPTH - 1, 16'h1234);
    do_read(5, 0, "R3 write word");
    do_read(DEPTH - 1, 0, "R3 write top word");
    do_read(0, 0, "R3 neighbour untouched");

    // R1: leading zeros before the start bit
    do_read(5, 3, "R1 leading zeros ignored");

    // R4: single erase
    m_erase(5);
    do_read(5, 0, "R4 erase word");
    do_read(DEPTH - 1, 0, "R4 other word kept");

    // R7: fill every word
    m_ext(1, 0, 16'hA5C3);
    do_read(0, 0, "R7 fill low");
    do_read(17, 0, "R7 fill mid");

    // R6: wipe every word
    m_write(9, 16'h0F0F);
    m_ext(2, 9, 16'h0);
    do_read(9, 0, "R6 wipe");
    do_read(DEPTH - 1, 0, "R6 wipe top");

    // R5/R8: lock, then programming is refused
    m_write(9, 16'h1357);
    m_ext(0, 6, 16'h0);
    m_write(9, 16'h2468);
    m_erase(9);
    m_ext(2, 0, 16'h0);
    do_read(9, 0, "R8 locked write/erase/wipe refused");
    m_ext(1, 0, 16'h7777);
    do_read(9, 0, "R5 lock blocks fill");

    // R10: abort mid data
    m_ext(3, 10, 16'h0);
    send_head(2'b01, 9, 0);
    for (int i = 0; i < 10; i++) clk_bit(1'b0);
    cs_down();
    do_read(9, 0, "R10 aborted write");
    send_head(2'b11, 9, 0);
    cs_down();
    // R10: erase head sent but address complete => erase happens; model it
    mdl[9] = 16'hFFFF;
    do_read(9, 0, "R4 erase after full address");

    // R10: abort during read output
    send_head(2'b10, 0, 0);
    exp_en = 1'b1; exp_dout = 1'b0;
    clk_bit(1'b0); exp_dout = mdl[0][15];
    cs_down();
    check(dout_en === 1'b0, "R10 abort read hiz", {15'd0, dout_en}, 16'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule